// File: doc/BRIEF.md
# Two-Phase Interval Timer with Watchdog Reset

This peripheral holds two independent down-counting timers behind a small word-addressed register bus. Each timer splits its period into two phases, a timeout phase followed by a pulse phase. Each phase is loaded from its own count register, so a full period lasts the sum of the two loaded values in clock cycles. At the end of every period a timer in normal mode gives a one-cycle interrupt pulse. It then reloads both phases and keeps running for as long as its enable bit stays set.

Timer 0 can instead act as a system watchdog. Software writes the sentinel 0xFF into the low byte of its timeout register and puts the watchdog count in the bits above it. From then on the end of the period raises a reset request rather than an interrupt. The request stays high until the block itself is reset. To reprogram a timer, software clears its enable bit, writes both count registers and sets the enable bit again. Setting the bit restarts the timer from the registers.

Top module: `dpt_timer`

## Requirements
- R1: After reset every register reads 0, both timers are disabled, and irq0, irq1 and rst_req are low.
- R2: Word addresses select the registers: 0 is control, 1 is timer 1 timeout, 2 is timer 0 timeout, 3 is timer 1 pulse and 4 is timer 0 pulse. Each count register reads back the full 32-bit value written to it. Any other address reads 0.
- R3: In the control word, bit 0 enables timer 0 and bit 1 enables timer 1. Bits 9:8 are read-only phase status: bit 8 belongs to timer 0 and bit 9 to timer 1, with 0 for the timeout phase and 1 for the pulse phase. All other control bits read back as written and have no effect.
- R4: Take the enable write edge as cycle 0. A normal-mode timer then pulses its interrupt for one cycle at cycle T+P, and again every T+P cycles after that. Here T is the timeout value and P is the pulse value.
- R5: A phase value of 0 counts as 1 cycle, so the shortest period is 2 cycles.
- R6: A 0-to-1 change of an enable bit reloads both phases from the registers and sets the phase status to 0. The timer then restarts a full period.
- R7: While its enable bit is clear, a timer produces no interrupt and its phase status holds.
- R8: When the low byte of the timer 0 timeout register is 0xFF, timer 0 is in watchdog mode and its timeout phase length is bits 31:8 of that register. In this mode the end of the period produces no irq0 pulse. Instead rst_req rises one cycle later, which is cycle T+P+1 after the enable edge.
- R9: Once rst_req is high it stays high, even with timer 0 disabled, until rst_n is asserted. Reset clears it.
- R10: The two timers run independently when both are enabled at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; combinational while rd_en is high, 0 otherwise |
| irq0 | output | 1 | Timer 0 end-of-period pulse |
| irq1 | output | 1 | Timer 1 end-of-period pulse |
| rst_req | output | 1 | Sticky watchdog reset request |

## Verification
The bench builds the block at its default 32-bit data width. This means full-width register readback and the 24-bit watchdog field are exercised as they are in use. The loaded counts are kept small, from 0 to 20 cycles per phase. This brings the zero-as-one rule, the 2-cycle minimum period and the one-cycle pulse within a few dozen clocks. The same holds for watchdog expiry, freeze and restart, and concurrent operation of both timers.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned NTMR     = 2;
  localparam int unsigned PH_LSB   = 8;
  localparam int unsigned WD_SHIFT = 8;
  localparam logic [7:0]  WD_KEY   = 8'hFF;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_T1_TO = 3'd1,
    A_T0_TO = 3'd2,
    A_T1_PD = 3'd3,
    A_T0_PD = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/dpt_rst_sync.sv
module dpt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  always_comb sh_n = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_n;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/dpt_regs.sv
module dpt_regs
  import dpt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NTMR-1:0]   phase,
  output logic [DATA_W-1:0] rdata,
  output logic [NTMR-1:0]   en_q,
  output logic [NTMR-1:0]   en_d,
  output logic [DATA_W-1:0] to_q [NTMR],
  output logic [DATA_W-1:0] pd_q [NTMR]
);
  logic [DATA_W-1:0] ctrl_q, ctrl_n;
  logic [DATA_W-1:0] to_n [NTMR];
  logic [DATA_W-1:0] pd_n [NTMR];

  function automatic logic [ADDR_W-1:0] to_addr(input int i);
    return (i == 0) ? A_T0_TO : A_T1_TO;
  endfunction

  function automatic logic [ADDR_W-1:0] pd_addr(input int i);
    return (i == 0) ? A_T0_PD : A_T1_PD;
  endfunction

  always_comb begin
    ctrl_n = ctrl_q;
    for (int i = 0; i < NTMR; i++) begin
      to_n[i] = to_q[i];
      pd_n[i] = pd_q[i];
    end
    if (wr_en) begin
      if (addr == A_CTRL) ctrl_n = wdata;
      for (int i = 0; i < NTMR; i++) begin
        if (addr == to_addr(i)) to_n[i] = wdata;
        if (addr == pd_addr(i)) pd_n[i] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      for (int i = 0; i < NTMR; i++) begin
        to_q[i] <= '0;
        pd_q[i] <= '0;
      end
    end else if (wr_en) begin
      ctrl_q <= ctrl_n;
      for (int i = 0; i < NTMR; i++) begin
        to_q[i] <= to_n[i];
        pd_q[i] <= pd_n[i];
      end
    end
  end

  assign en_q = ctrl_q[NTMR-1:0];
  assign en_d = ctrl_n[NTMR-1:0];

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTRL: begin
          rdata = ctrl_q;
          rdata[PH_LSB +: NTMR] = phase;
        end
        A_T1_TO: rdata = to_q[1];
        A_T0_TO: rdata = to_q[0];
        A_T1_PD: rdata = pd_q[1];
        A_T0_PD: rdata = pd_q[0];
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dpt_phase_counter.sv
module dpt_phase_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_q,
  input  logic              en_d,
  input  logic              alt_mode,
  input  logic [DATA_W-1:0] tmo_val,
  input  logic [DATA_W-1:0] pls_val,
  output logic              phase,
  output logic              irq,
  output logic              trip
);
  logic [DATA_W-1:0] cnt_q, cnt_n;
  logic              ph_q, ph_n;
  logic              irq_q, irq_n;
  logic              trip_q, trip_n;
  logic              wrap;

  function automatic logic [DATA_W-1:0] first(input logic [DATA_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  always_comb begin
    cnt_n = cnt_q;
    ph_n  = ph_q;
    wrap  = 1'b0;
    if (en_d) begin
      if (!en_q) begin
        cnt_n = first(tmo_val);
        ph_n  = 1'b0;
      end else if (cnt_q != '0) begin
        cnt_n = cnt_q - 1'b1;
      end else if (!ph_q) begin
        cnt_n = first(pls_val);
        ph_n  = 1'b1;
      end else begin
        cnt_n = first(tmo_val);
        ph_n  = 1'b0;
        wrap  = 1'b1;
      end
    end
    irq_n  = wrap & ~alt_mode;
    trip_n = wrap & alt_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      irq_q  <= 1'b0;
      trip_q <= 1'b0;
    end else begin
      irq_q  <= irq_n;
      trip_q <= trip_n;
      if (en_d) begin
        cnt_q <= cnt_n;
        ph_q  <= ph_n;
      end
    end
  end

  assign phase = ph_q;
  assign irq   = irq_q;
  assign trip  = trip_q;
endmodule

// File: rtl/dpt_wd_latch.sv
module dpt_wd_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  output logic req
);
  logic req_q, req_n;

  always_comb req_n = req_q | trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_n;
  end

  assign req = req_q;
endmodule

// File: rtl/dpt_timer.sv
module dpt_timer
  import dpt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq0,
  output logic              irq1,
  output logic              rst_req
);
  logic              rst_sync_n;
  logic [NTMR-1:0]   en_q, en_d, phase, irq_v, trip_v, alt_v;
  logic [DATA_W-1:0] to_q [NTMR];
  logic [DATA_W-1:0] pd_q [NTMR];
  logic [DATA_W-1:0] tmo_sel [NTMR];
  logic              wd_mode;

  dpt_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_sync_n)
  );

  dpt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .phase(phase), .rdata(rdata),
    .en_q(en_q), .en_d(en_d), .to_q(to_q), .pd_q(pd_q)
  );

  assign wd_mode = (to_q[0][7:0] == WD_KEY);

  generate
    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
      if (g == 0) begin : g_wd
        assign alt_v[g]   = wd_mode;
        assign tmo_sel[g] = wd_mode ? (to_q[g] >> WD_SHIFT) : to_q[g];
      end else begin : g_plain
        assign alt_v[g]   = 1'b0;
        assign tmo_sel[g] = to_q[g];
      end

      dpt_phase_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_sync_n), .en_q(en_q[g]), .en_d(en_d[g]),
        .alt_mode(alt_v[g]), .tmo_val(tmo_sel[g]), .pls_val(pd_q[g]),
        .phase(phase[g]), .irq(irq_v[g]), .trip(trip_v[g])
      );
    end
  endgenerate

  dpt_wd_latch u_wd_latch (
    .clk(clk), .rst_n(rst_sync_n), .trip(trip_v[0]), .req(rst_req)
  );

  assign irq0 = irq_v[0];
  assign irq1 = irq_v[1];

  logic unused_trip;
  assign unused_trip = trip_v[1];
endmodule

// File: rtl/dpt_checker.sv
module dpt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       irq0,
  input logic       irq1,
  input logic       rst_req,
  input logic [1:0] en_q,
  input logic [1:0] en_d,
  input logic [1:0] phase,
  input logic       wd_mode
);
  assert_irq1_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 |=> !irq1);

  assert_irq0_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 |=> !irq0);

  assert_irq_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq1 |-> en_q[1]) and (irq0 |-> en_q[0]));

  assert_phase_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[1] && !en_d[1]) |=> $stable(phase[1]));

  assert_no_irq0_in_wd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 |-> $past(!wd_mode));

  assert_rst_from_wd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(wd_mode, 2));

  assert_rst_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
endmodule

bind dpt_timer dpt_checker u_dpt_checker (
  .clk(clk), .rst_n(rst_sync_n), .irq0(irq0), .irq1(irq1),
  .rst_req(rst_req), .en_q(en_q), .en_d(en_d), .phase(phase),
  .wd_mode(wd_mode)
);

// File: tb/test_dpt_timer.sv
module test_dpt_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq0, irq1, rst_req;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dpt_timer i_dpt_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq0(irq0), .irq1(irq1), .rst_req(rst_req)
  );

  localparam int NV = 6;
  localparam int unsigned V_SEL [NV] = '{1, 1, 1, 0, 0, 1};
  localparam int unsigned V_T   [NV] = '{3, 0, 1, 6, 0, 20};
  localparam int unsigned V_P   [NV] = '{4, 0, 1, 2, 9, 1};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic measure(input int sel, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!((sel == 0) ? irq0 : irq1) && n < 500);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL R4 watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n, cnt0, cnt1, te, pe;
    wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 reg after reset", d, 32'h0);
    end
    chk("R1 outputs after reset", {29'h0, irq0, irq1, rst_req}, 32'h0);

    // R2 map and readback
    wr(3'd3, 32'hDEADBEEF);
    rd(3'd3, d); chk("R2 t1 pulse readback", d, 32'hDEADBEEF);
    wr(3'd2, 32'h12345678);
    rd(3'd2, d); chk("R2 t0 timeout readback", d, 32'h12345678);
    rd(3'd5, d); chk("R2 unmapped reads 0", d, 32'h0);

    // R3 spare control bits have no effect, phase bits are read-only
    wr(3'd0, 32'hF0F0F7FC);
    rd(3'd0, d); chk("R3 control readback", d, 32'hF0F0F4FC);
    cnt0 = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq0 || irq1) cnt0++;
    end
    chk("R3 spare bits start nothing", cnt0, 0);
    wr(3'd0, 32'h0);

    // R4 / R5 vector table
    for (int v = 0; v < NV; v++) begin
      te = (V_T[v] == 0) ? 1 : V_T[v];
      pe = (V_P[v] == 0) ? 1 : V_P[v];
      wr(3'd0, 32'h0);
      wr((V_SEL[v] == 0) ? 3'd2 : 3'd1, V_T[v]);
      wr((V_SEL[v] == 0) ? 3'd4 : 3'd3, V_P[v]);
      wr(3'd0, 32'(1 << V_SEL[v]));
      measure(V_SEL[v], n);
      chk((V_T[v] == 0 || V_P[v] == 0) ? "R5 first period" : "R4 first period", n, te + pe);
      measure(V_SEL[v], n);
      chk((V_T[v] == 0 || V_P[v] == 0) ? "R5 repeat period" : "R4 repeat period", n, te + pe);
    end
    wr(3'd0, 32'h0);

    // R7 freeze and R6 restart
    wr(3'd1, 32'd5);
    wr(3'd3, 32'd5);
    wr(3'd0, 32'h2);
    repeat (7) @(negedge clk);
    rd(3'd0, d); chk("R3 pulse phase status", d[9], 1'b1);
    wr(3'd0, 32'h0);
    cnt1 = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (irq1) cnt1++;
    end
    chk("R7 no irq while disabled", cnt1, 0);
    rd(3'd0, d); chk("R7 phase held while disabled", d[9], 1'b1);
    wr(3'd0, 32'h2);
    rd(3'd0, d); chk("R6 phase reset on enable", d[9], 1'b0);
    measure(1, n);
    chk("R6 full period after restart", n, 10);
    wr(3'd0, 32'h0);

    // R10 concurrent operation
    wr(3'd2, 32'd2); wr(3'd4, 32'd2);
    wr(3'd1, 32'd3); wr(3'd3, 32'd3);
    wr(3'd0, 32'h3);
    cnt0 = 0; cnt1 = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (irq0) cnt0++;
      if (irq1) cnt1++;
    end
    chk("R10 timer0 pulses in 24 cycles", cnt0, 6);
    chk("R10 timer1 pulses in 24 cycles", cnt1, 4);
    wr(3'd0, 32'h0);

    // R8 watchdog
    wr(3'd2, (32'd10 << 8) | 32'hFF);
    wr(3'd4, 32'd3);
    wr(3'd0, 32'h1);
    n = 0; cnt0 = 0;
    do begin
      @(negedge clk);
      n++;
      if (irq0) cnt0++;
    end while (!rst_req && n < 500);
    chk("R8 reset request latency", n, 14);
    chk("R8 no irq0 in watchdog mode", cnt0, 0);

    // R9 sticky until reset
    wr(3'd0, 32'h0);
    repeat (20) @(negedge clk);
    chk("R9 request stays high", rst_req, 1'b1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 request cleared by reset", rst_req, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd2, d); chk("R9 registers cleared by reset", d, 32'h0);
    chk("R9 request low after release", rst_req, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule